// File: doc/BRIEF.md
# Floating-Point Class Matcher

This block tests one extended-format floating-point operand (sign, 17-bit exponent, 64-bit significand with an explicit integer bit) against a 9-bit class mask. It writes a complementary predicate pair. The operand is decoded into exactly one category, and the block also keeps its sign. The categories are: not-a-thing marker, quiet NaN, signaling NaN, zero, unnormal, normal and infinity. The three special categories are selected directly by their own mask bits. The four numeric categories are selected only when the mask also accepts the operand's sign.

A match/not-match select sets the sense of the result. The predicate write follows the rules used by the comparator. When the qualifying predicate is 1, the first predicate receives the result and the second predicate receives its complement. When the qualifying predicate is 0, the unconditional type writes 0 to both predicates and the normal type writes nothing. An issue strobe marks the cycles in which the execution slot carries a classify operation. The write is presented one clock after issue. Classification raises no floating-point exception flags.

Top module: `fp_class_match`

## Requirements
- R1: The operand is `{sign[81], exp[80:64], sig[63:0]}`, and every operand falls into exactly one category. The not-a-thing marker is sign 0, exp 0x1FFFE, sig 0. With exp 0x1FFFF: infinity when sig[62:0] is 0, otherwise quiet NaN when sig[62] is 1 and signaling NaN when sig[62] is 0. With exp 0: zero when sig is 0, otherwise unnormal. Any other exponent gives normal when sig[63] is 1 and unnormal otherwise.
- R2: Mask bit 8 selects the not-a-thing marker, bit 7 selects quiet NaN and bit 6 selects signaling NaN. An operand in one of these categories tests true exactly when its own bit is set, whatever its sign and mask bits 0 to 5.
- R3: For zero, unnormal, normal and infinity (mask bits 2, 3, 4, 5) the test is true only when the category bit is set AND the sign is accepted: bit 0 accepts positive and bit 1 accepts negative.
- R4: With not-match 0, the first predicate (pred_o[0]) is written with the test result. With not-match 1, it is written with the inverted result.
- R5: Every write with the qualifying predicate at 1 sets the second predicate (pred_o[1]) to the complement of the first.
- R6: An issued operation with the qualifying predicate at 0 and the unconditional select at 1 writes 0 to both predicates.
- R7: An issued operation with the qualifying predicate at 0 and the unconditional select at 0 produces no write. A cycle without issue also produces no write. Whenever there is no write, pred_o is 0.
- R8: The write enable and values appear on the first rising clock edge after the inputs are presented. After reset, pred_we_o is 0 and pred_o is 0.
- R9: Unnormal covers a nonzero exponent below 0x1FFFF with sig[63] at 0, including a zero significand and the encoding 0x1FFFE with sign 1. It also covers exponent 0 with any nonzero significand, including the form with the integer bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Slot carries a classify operation this cycle |
| qp_i | input | 1 | Qualifying predicate |
| uncond_i | input | 1 | 1 selects the unconditional write type |
| not_match_i | input | 1 | 1 inverts the sense of the test |
| mask_i | input | 9 | Class selection mask |
| operand_i | input | 82 | Extended-format operand |
| pred_we_o | output | 1 | Predicate pair write enable |
| pred_o | output | 2 | Bit 0 first predicate, bit 1 second predicate |

## Verification
Decoding, the mask test and the write rule are combinational. They feed one output register, so each write enable and predicate pair is due on the first rising edge after the operand, mask and control inputs are held. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, half a cycle after the capturing edge. After each check it drops issue for a cycle, so the result of every operation is read alone and cannot carry into the next.

// File: rtl/fpcm_pkg.sv
package fpcm_pkg;
  localparam int MASK_W = 9;
  // mask bit positions
  localparam int MB_POS    = 0;
  localparam int MB_NEG    = 1;
  localparam int MB_ZERO   = 2;
  localparam int MB_UNNORM = 3;
  localparam int MB_NORM   = 4;
  localparam int MB_INF    = 5;
  localparam int MB_SNAN   = 6;
  localparam int MB_QNAN   = 7;
  localparam int MB_NATVAL = 8;
  // category index k is selected by mask bit k + MB_ZERO
  localparam int CAT_N     = 7;
  localparam int CI_ZERO   = 0;
  localparam int CI_UNNORM = 1;
  localparam int CI_NORM   = 2;
  localparam int CI_INF    = 3;
  localparam int CI_SNAN   = 4;
  localparam int CI_QNAN   = 5;
  localparam int CI_NATVAL = 6;

  typedef struct packed {
    logic             sign;
    logic [CAT_N-1:0] cat;
  } fpcm_class_t;
endpackage

// File: rtl/fpcm_decode.sv
module fpcm_decode
  import fpcm_pkg::*;
#(
  parameter int EXP_W = 17,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W+SIG_W:0] op_i,
  output fpcm_class_t          cls_o
);
  localparam int QBIT = SIG_W - 2;
  localparam int IBIT = SIG_W - 1;
  localparam logic [EXP_W-1:0] EXP_NATVAL = {{(EXP_W-1){1'b1}}, 1'b0};

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [SIG_W-1:0] sg;
  logic             exp_max, exp_zero, exp_natval, sig_zero, frac_zero;
  logic [CAT_N-1:0] cat;

  assign {sgn, ex, sg} = op_i;
  assign exp_max    = &ex;
  assign exp_zero   = ~|ex;
  assign exp_natval = (ex == EXP_NATVAL);
  assign sig_zero   = ~|sg;
  assign frac_zero  = ~|sg[QBIT:0];

  always_comb begin
    cat = '0;
    if (!sgn && exp_natval && sig_zero)  cat[CI_NATVAL] = 1'b1;
    else if (exp_max) begin
      if (frac_zero)                     cat[CI_INF]    = 1'b1;
      else if (sg[QBIT])                 cat[CI_QNAN]   = 1'b1;
      else                               cat[CI_SNAN]   = 1'b1;
    end else if (exp_zero) begin
      if (sig_zero)                      cat[CI_ZERO]   = 1'b1;
      else                               cat[CI_UNNORM] = 1'b1; // denormal / pseudo-denormal
    end else if (sg[IBIT])               cat[CI_NORM]   = 1'b1;
    else                                 cat[CI_UNNORM] = 1'b1;
  end

  assign cls_o.sign = sgn;
  assign cls_o.cat  = cat;
endmodule

// File: rtl/fpcm_eval.sv
module fpcm_eval
  import fpcm_pkg::*;
(
  input  fpcm_class_t       cls_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              hit_o
);
  logic             sign_ok;
  logic [CAT_N-1:0] term;

  assign sign_ok = cls_i.sign ? mask_i[MB_NEG] : mask_i[MB_POS];

  for (genvar k = 0; k < CAT_N; k++) begin : g_term
    if (k <= CI_INF) begin : g_signed
      assign term[k] = cls_i.cat[k] & mask_i[k+MB_ZERO] & sign_ok;
    end else begin : g_special
      assign term[k] = cls_i.cat[k] & mask_i[k+MB_ZERO];
    end
  end

  assign hit_o = |term;
endmodule

// File: rtl/fpcm_pred_wr.sv
module fpcm_pred_wr (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic       qp_i,
  input  logic       uncond_i,
  input  logic       not_match_i,
  input  logic       hit_i,
  output logic       pred_we_o,
  output logic [1:0] pred_o
);
  logic       we_d;
  logic [1:0] val_d;
  logic       res;

  assign res = hit_i ^ not_match_i;

  always_comb begin
    we_d  = 1'b0;
    val_d = 2'b00;
    if (issue_i) begin
      if (qp_i) begin
        we_d  = 1'b1;
        val_d = {~res, res};
      end else if (uncond_i) begin
        we_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_we_o <= 1'b0;
      pred_o    <= 2'b00;
    end else begin
      pred_we_o <= we_d;
      pred_o    <= val_d;
    end
  end
endmodule

// File: rtl/fp_class_match.sv
module fp_class_match
  import fpcm_pkg::*;
#(
  parameter int EXP_W = 17,
  parameter int SIG_W = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    issue_i,
  input  logic                    qp_i,
  input  logic                    uncond_i,
  input  logic                    not_match_i,
  input  logic [MASK_W-1:0]       mask_i,
  input  logic [EXP_W+SIG_W:0]    operand_i,
  output logic                    pred_we_o,
  output logic [1:0]              pred_o
);
  fpcm_class_t cls;
  logic        hit;

  fpcm_decode #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_decode (
    .op_i  (operand_i),
    .cls_o (cls)
  );

  fpcm_eval u_eval (
    .cls_i  (cls),
    .mask_i (mask_i),
    .hit_o  (hit)
  );

  fpcm_pred_wr u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .qp_i        (qp_i),
    .uncond_i    (uncond_i),
    .not_match_i (not_match_i),
    .hit_i       (hit),
    .pred_we_o   (pred_we_o),
    .pred_o      (pred_o)
  );
endmodule

// File: rtl/fp_class_match_chk.sv
module fp_class_match_chk
  import fpcm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic              qp_i,
  input logic              uncond_i,
  input logic              not_match_i,
  input logic [MASK_W-1:0] mask_i,
  input logic              sign_i,
  input logic [CAT_N-1:0]  cat_i,
  input logic              hit_i,
  input logic              pred_we_o,
  input logic [1:0]        pred_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_one_category_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cat_i) == 1);

  assert_no_selected_class_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cat_i & mask_i[MB_NATVAL:MB_ZERO]) == '0) |-> !hit_i);

  assert_sign_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cat_i[CI_INF:CI_ZERO]) && !(sign_i ? mask_i[MB_NEG] : mask_i[MB_POS])) |-> !hit_i);

  assert_sense_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(issue_i && qp_i)) |-> (pred_o[0] == ($past(hit_i) ^ $past(not_match_i))));

  assert_complement_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(issue_i && qp_i)) |-> (pred_we_o && (pred_o[1] != pred_o[0])));

  assert_uncond_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(issue_i && !qp_i && uncond_i)) |-> (pred_we_o && pred_o == 2'b00));

  assert_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(!issue_i || (!qp_i && !uncond_i))) |-> (!pred_we_o && pred_o == 2'b00));
endmodule

bind fp_class_match fp_class_match_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .issue_i     (issue_i),
  .qp_i        (qp_i),
  .uncond_i    (uncond_i),
  .not_match_i (not_match_i),
  .mask_i      (mask_i),
  .sign_i      (cls.sign),
  .cat_i       (cls.cat),
  .hit_i       (hit),
  .pred_we_o   (pred_we_o),
  .pred_o      (pred_o)
);

// File: tb/fp_class_match_bench.sv
`timescale 1ns/1ps
module fp_class_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0, qp = 1'b0, unc = 1'b0, nm = 1'b0;
  logic [8:0]  mask = '0;
  logic [81:0] opnd = '0;
  logic        we;
  logic [1:0]  pr;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  // bench category codes
  localparam int K_ZERO = 0, K_UNN = 1, K_NORM = 2, K_INF = 3, K_SNAN = 4, K_QNAN = 5, K_NAT = 6;

  always #2.5 clk = ~clk;

  fp_class_match u_fp_class_match (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .qp_i(qp), .uncond_i(unc),
    .not_match_i(nm), .mask_i(mask), .operand_i(opnd), .pred_we_o(we), .pred_o(pr)
  );

  function automatic logic [81:0] mk(input bit s, input logic [16:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  function automatic bit exp_hit(input int k, input bit s, input logic [8:0] m);
    bit sok = s ? m[1] : m[0];
    case (k)
      K_NAT:   return m[8];
      K_QNAN:  return m[7];
      K_SNAN:  return m[6];
      K_INF:   return m[5] & sok;
      K_NORM:  return m[4] & sok;
      K_UNN:   return m[3] & sok;
      default: return m[2] & sok;
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual we/p1/p0=%b expected=%b", req, act, expv);
    end
  endtask

  // present one operation, read the write one edge later, then idle a cycle
  task automatic run(input string req, input logic [81:0] o, input int k, input logic [8:0] m,
                     input bit n, input bit q, input bit u);
    bit r;
    logic [2:0] e;
    @(negedge clk);
    opnd = o; mask = m; nm = n; qp = q; unc = u; issue = 1'b1;
    r = exp_hit(k, o[81], m) ^ n;
    if (q)      e = {1'b1, ~r, r};
    else if (u) e = 3'b100;
    else        e = 3'b000;
    @(negedge clk);
    check(req, {we, pr}, e);
    issue = 1'b0;
    @(negedge clk);
    check({req, " idle R7"}, {we, pr}, 3'b000);
  endtask

  localparam logic [63:0] IB = 64'h8000_0000_0000_0000;

  task automatic t_reset();
    check("R8 reset", {we, pr}, 3'b000);
  endtask

  task automatic t_categories();  // R1 R9: each operand hits only its own class bit
    run("R1 +norm",       mk(0, 17'h0FFFF, IB), K_NORM, 9'b0_0001_0001, 0, 1, 0);
    run("R1 -zero",       mk(1, 17'h0, 64'h0), K_ZERO, 9'b0_0000_0110, 0, 1, 0);
    run("R1 +inf",        mk(0, 17'h1FFFF, IB), K_INF, 9'b0_0010_0001, 0, 1, 0);
    run("R1 inf no int",  mk(1, 17'h1FFFF, 64'h0), K_INF, 9'b0_0010_0010, 0, 1, 0);
    run("R1 qnan",        mk(0, 17'h1FFFF, 64'hC000_0000_0000_0000), K_QNAN, 9'b0_1000_0000, 0, 1, 0);
    run("R1 snan",        mk(0, 17'h1FFFF, IB | 64'h1), K_SNAN, 9'b0_0100_0000, 0, 1, 0);
    run("R1 natval",      mk(0, 17'h1FFFE, 64'h0), K_NAT, 9'b1_0000_0000, 0, 1, 0);
    run("R1 natval miss", mk(0, 17'h1FFFE, 64'h0), K_NAT, 9'b0_1111_1111, 0, 1, 0);
    run("R9 unnorm",      mk(0, 17'h01000, 64'h4000_0000_0000_0000), K_UNN, 9'b0_0000_1001, 0, 1, 0);
    run("R9 unnorm sig0", mk(0, 17'h00005, 64'h0), K_UNN, 9'b0_0000_0101, 0, 1, 0);
    run("R9 neg 1FFFE",   mk(1, 17'h1FFFE, 64'h0), K_UNN, 9'b0_0000_1010, 0, 1, 0);
    run("R9 denormal",    mk(0, 17'h0, 64'h1), K_UNN, 9'b0_0000_1001, 0, 1, 0);
    run("R9 pseudo-den",  mk(0, 17'h0, IB), K_UNN, 9'b0_0001_0101, 0, 1, 0);
  endtask

  task automatic t_sign_and();    // R3
    run("R3 no sign",    mk(0, 17'h0FFFF, IB), K_NORM, 9'b0_0001_0000, 0, 1, 0);
    run("R3 wrong sign", mk(0, 17'h0FFFF, IB), K_NORM, 9'b0_0001_0010, 0, 1, 0);
    run("R3 neg inf",    mk(1, 17'h1FFFF, IB), K_INF, 9'b0_0010_0010, 0, 1, 0);
    run("R3 neg zero +", mk(1, 17'h0, 64'h0), K_ZERO, 9'b0_0011_1101, 0, 1, 0);
  endtask

  task automatic t_specials();    // R2: sign and numeric bits do not select NaNs
    run("R2 qnan numeric", mk(1, 17'h1FFFF, 64'hC000_0000_0000_0001), K_QNAN, 9'b0_0011_1111, 0, 1, 0);
    run("R2 snan neg",     mk(1, 17'h1FFFF, 64'h0000_0000_0000_0100), K_SNAN, 9'b0_0100_0000, 0, 1, 0);
    run("R2 snan vs qbit", mk(0, 17'h1FFFF, IB | 64'h2), K_SNAN, 9'b0_1000_0011, 0, 1, 0);
  endtask

  task automatic t_not_match();   // R4 R5
    run("R4 nm hit",  mk(0, 17'h0FFFF, IB), K_NORM, 9'b0_0001_0001, 1, 1, 0);
    run("R4 nm miss", mk(0, 17'h0FFFF, IB), K_NORM, 9'b0_0010_0001, 1, 1, 0);
    run("R5 unc qp1", mk(0, 17'h1FFFF, 64'hC000_0000_0000_0000), K_QNAN, 9'b0_1000_0000, 0, 1, 1);
  endtask

  task automatic t_qual();        // R6 R7
    run("R6 unc qp0",    mk(0, 17'h0FFFF, IB), K_NORM, 9'b0_0001_0001, 0, 0, 1);
    run("R6 unc qp0 nm", mk(0, 17'h0FFFF, IB), K_NORM, 9'b0_0000_0000, 1, 0, 1);
    run("R7 norm qp0",   mk(0, 17'h0FFFF, IB), K_NORM, 9'b0_0001_0001, 0, 0, 0);
    // R7: no issue means no write even with qp high
    @(negedge clk);
    opnd = mk(0, 17'h0FFFF, IB); mask = 9'h1FF; qp = 1'b1; unc = 1'b1; issue = 1'b0;
    @(negedge clk);
    check("R7 no issue", {we, pr}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_categories();
    t_sign_and();
    t_specials();
    t_not_match();
    t_qual();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule